// File: doc/BRIEF.md
# Program Counter Address-Match Interrupt Unit

This unit watches the program counter of a processor core and raises an interrupt request when an instruction begins at one of several programmed addresses. It has four channels. Each channel holds a 24-bit target address and an enable bit. The core reports the program counter together with a strobe. The strobe is high only on the first fetch of each instruction, so a target that lies inside an instruction or in a data table never causes a request.

Software programs the unit through a byte-wide register bus. The unit has no input for the global interrupt-enable flag or the priority level, so neither can mask its requests. When a request fires, the unit reports the lowest-numbered matching channel. It also keeps one sticky status bit per channel, and software clears a status bit by writing 1 to it.

Top module: `pc_match_irq`

## Requirements
- R1: After reset, every target address is 0x000000, every enable bit is 0, all status bits are 0 and `irq_req` is 0. A read of any register returns 0.
- R2: The target address of channel c occupies three byte offsets: 0x10+4c holds bits 7:0, 0x10+4c+1 holds bits 15:8 and 0x10+4c+2 holds bits 23:16. Each byte reads back what was written to it.
- R3: The enable register is at offset 0x09, and bit c enables channel c when it is 1. Bits 7:4 read as 0 whatever value was written to them.
- R4: When an enabled channel's target equals `pc` in a cycle where `pc_start` is 1, `irq_req` is 1 in the next cycle only and `irq_chan` gives that channel.
- R5: A matching `pc` with `pc_start` at 0 produces no request and sets no status bit.
- R6: A channel whose enable bit is 0 never produces a request and never sets its status bit.
- R7: When several enabled channels match on the same strobe, `irq_chan` reports the lowest-numbered one.
- R8: Every enabled channel that matches on a strobe sets its own status bit, readable on `hit_status` and at offset 0x0B. The bit stays set across later strobes.
- R9: Writing to offset 0x0B clears each status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged. If a match sets a bit in the same cycle that a write clears it, the bit stays set.
- R10: A comparison made in the same cycle as a write to a target register uses the target value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pc | input | 24 | Current program counter |
| pc_start | input | 1 | High on the first fetch of an instruction |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_chan | output | 2 | Index of the reported channel |
| hit_status | output | 4 | Sticky per-channel match flags |

## Verification
The bench presents program counters that match a single channel, two channels with the same target, the all-zero and all-ones addresses, and an address one above a target. These cases separate equality from near-equality, show which channel wins when several match, and show which status bits are set. Directed cases repeat a matching counter with the strobe low and with the channel disabled, to show that both the strobe and the enable gate the request. Other directed cases place a target write and a status clear in the same cycle as a strobe, to expose the ordering between the register bus and the comparison.

// File: rtl/am_pkg.sv
package am_pkg;
    localparam int NUM_CH       = 4;
    localparam int ADDR_W       = 24;
    localparam int BUS_AW       = 5;
    localparam int BUS_DW       = 8;
    localparam int TGT_BASE     = 16;
    localparam int TGT_STRIDE   = 4;
    localparam int ENA_OFF      = 9;
    localparam int STAT_OFF     = 11;

    function automatic int bytes_for(input int width, input int dw);
        return (width + dw - 1) / dw;
    endfunction

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/am_chan_cmp.sv
module am_chan_cmp #(
    parameter int ADDR_W = am_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] pc,
    input  logic              pc_start,
    input  logic [ADDR_W-1:0] target,
    input  logic              enable,
    output logic              hit
);
    assign hit = enable && pc_start && (pc == target);

    // R6
    hit_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> (enable && pc_start));
endmodule

// File: rtl/am_pick.sv
module am_pick #(
    parameter int NUM_CH = am_pkg::NUM_CH,
    localparam int IDX_W = am_pkg::idx_width(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] hits,
    output logic              any,
    output logic [IDX_W-1:0]  idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (hits[c]) begin
                any = 1'b1;
                idx = IDX_W'(c);
            end
        end
    end

    // R7
    lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
        any |-> (hits[idx] && ((hits & ((NUM_CH'(1) << idx) - NUM_CH'(1))) == '0)));
endmodule

// File: rtl/am_regs.sv
module am_regs #(
    parameter int NUM_CH = am_pkg::NUM_CH,
    parameter int ADDR_W = am_pkg::ADDR_W,
    parameter int BUS_AW = am_pkg::BUS_AW,
    parameter int BUS_DW = am_pkg::BUS_DW,
    localparam int NB    = am_pkg::bytes_for(ADDR_W, BUS_DW)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          bus_wr,
    input  logic [BUS_AW-1:0]             bus_addr,
    input  logic [BUS_DW-1:0]             bus_wdata,
    output logic [BUS_DW-1:0]             bus_rdata,
    input  logic [NUM_CH-1:0]             hits,
    output logic [NUM_CH-1:0][ADDR_W-1:0] targets,
    output logic [NUM_CH-1:0]             enables,
    output logic [NUM_CH-1:0]             status
);
    localparam logic [BUS_AW-1:0] ENA_A  = BUS_AW'(am_pkg::ENA_OFF);
    localparam logic [BUS_AW-1:0] STAT_A = BUS_AW'(am_pkg::STAT_OFF);

    logic [NUM_CH-1:0] clr_mask;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        for (genvar b = 0; b < NB; b++) begin : g_byte
            localparam int LO = b * BUS_DW;
            localparam int W  = (ADDR_W - LO < BUS_DW) ? (ADDR_W - LO) : BUS_DW;
            localparam logic [BUS_AW-1:0] OFF =
                BUS_AW'(am_pkg::TGT_BASE + c * am_pkg::TGT_STRIDE + b);
            always_ff @(posedge clk) begin
                if (rst)
                    targets[c][LO +: W] <= '0;
                else if (bus_wr && bus_addr == OFF)
                    targets[c][LO +: W] <= bus_wdata[W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            enables <= '0;
        else if (bus_wr && bus_addr == ENA_A)
            enables <= bus_wdata[NUM_CH-1:0];
    end

    assign clr_mask = (bus_wr && bus_addr == STAT_A) ? bus_wdata[NUM_CH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst)
            status <= '0;
        else
            status <= (status & ~clr_mask) | hits;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ENA_A)
            bus_rdata[NUM_CH-1:0] = enables;
        else if (bus_addr == STAT_A)
            bus_rdata[NUM_CH-1:0] = status;
        for (int c = 0; c < NUM_CH; c++) begin
            for (int b = 0; b < NB; b++) begin
                if (bus_addr == BUS_AW'(am_pkg::TGT_BASE + c * am_pkg::TGT_STRIDE + b))
                    bus_rdata = BUS_DW'(targets[c] >> (b * BUS_DW));
            end
        end
    end

    // R9
    status_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(status) & ~$past(clr_mask) & ~status) == '0));

    // R3
    ena_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ENA_A) |-> (bus_rdata[BUS_DW-1:NUM_CH] == '0));
endmodule

// File: rtl/pc_match_irq.sv
module pc_match_irq #(
    parameter int NUM_CH = am_pkg::NUM_CH,
    parameter int ADDR_W = am_pkg::ADDR_W,
    parameter int BUS_AW = am_pkg::BUS_AW,
    parameter int BUS_DW = am_pkg::BUS_DW,
    localparam int IDX_W = am_pkg::idx_width(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic [ADDR_W-1:0] pc,
    input  logic              pc_start,
    output logic              irq_req,
    output logic [IDX_W-1:0]  irq_chan,
    output logic [NUM_CH-1:0] hit_status
);
    logic [NUM_CH-1:0][ADDR_W-1:0] targets;
    logic [NUM_CH-1:0]             enables;
    logic [NUM_CH-1:0]             hits;
    logic                          pick_any;
    logic [IDX_W-1:0]              pick_idx;

    am_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BUS_AW(BUS_AW), .BUS_DW(BUS_DW)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hits(hits),
        .targets(targets), .enables(enables), .status(hit_status)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
        am_chan_cmp #(.ADDR_W(ADDR_W)) u_cmp (
            .clk(clk), .rst(rst), .pc(pc), .pc_start(pc_start),
            .target(targets[c]), .enable(enables[c]), .hit(hits[c])
        );
    end

    am_pick #(.NUM_CH(NUM_CH)) u_pick (
        .clk(clk), .rst(rst), .hits(hits), .any(pick_any), .idx(pick_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_req  <= 1'b0;
            irq_chan <= '0;
        end else begin
            irq_req  <= pick_any;
            irq_chan <= pick_any ? pick_idx : irq_chan;
        end
    end

    // R5
    req_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> $past(pc_start));

    // R8
    req_sets_status_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> hit_status[irq_chan]);
endmodule

// File: tb/pc_match_irq_tb.sv
module pc_match_irq_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [23:0] pc = '0;
    logic       pc_start = 1'b0;
    logic       irq_req;
    logic [1:0] irq_chan;
    logic [3:0] hit_status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pc_match_irq u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pc(pc),
        .pc_start(pc_start), .irq_req(irq_req), .irq_chan(irq_chan),
        .hit_status(hit_status)
    );

    // {pc, expected request, expected channel, expected status}
    localparam logic [30:0] VEC [6] = '{
        {24'h001234, 1'b1, 2'd0, 4'b0001},
        {24'hABCDEF, 1'b1, 2'd1, 4'b0010},
        {24'h7F0000, 1'b1, 2'd2, 4'b1100},
        {24'h000000, 1'b0, 2'd0, 4'b0000},
        {24'hFFFFFF, 1'b0, 2'd0, 4'b0000},
        {24'h001235, 1'b0, 2'd0, 4'b0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_target(input int c, input logic [23:0] v);
        for (int b = 0; b < 3; b++) wr(5'(16 + 4 * c + b), v[8*b +: 8]);
    endtask

    task automatic strobe(input logic [23:0] v, input logic st);
        @(negedge clk);
        pc = v; pc_start = st;
        @(negedge clk);
        pc_start = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 irq_req", 32'(irq_req), 0);
        check("R1 status", 32'(hit_status), 0);
        for (int a = 0; a < 32; a++) begin
            rd(5'(a), d);
            check("R1 read zero", 32'(d), 0);
        end

        // R2 byte layout and readback
        set_target(0, 24'h001234);
        set_target(1, 24'hABCDEF);
        set_target(2, 24'h7F0000);
        set_target(3, 24'h7F0000);
        rd(5'h14, d); check("R2 ch1 byte0", 32'(d), 32'hEF);
        rd(5'h15, d); check("R2 ch1 byte1", 32'(d), 32'hCD);
        rd(5'h16, d); check("R2 ch1 byte2", 32'(d), 32'hAB);
        rd(5'h17, d); check("R2 gap byte", 32'(d), 0);

        // R3 enable register, upper bits read 0
        wr(5'h09, 8'hFF);
        rd(5'h09, d); check("R3 enable readback", 32'(d), 32'h0F);

        // R4 R7 R8 vector table
        for (int i = 0; i < 6; i++) begin
            strobe(VEC[i][30:7], 1'b1);
            check("R4 req", 32'(irq_req), 32'(VEC[i][6]));
            if (VEC[i][6]) check("R7 chan", 32'(irq_chan), 32'(VEC[i][5:4]));
            check("R8 status", 32'(hit_status), 32'(VEC[i][3:0]));
            @(negedge clk);
            check("R4 one-cycle pulse", 32'(irq_req), 0);
            wr(5'h0B, 8'h0F);
        end

        // R8 sticky across later strobes, readable at 0x0B
        strobe(24'h001234, 1'b1);
        strobe(24'h000000, 1'b1);
        rd(5'h0B, d); check("R8 sticky status", 32'(d), 32'h01);

        // R9 write 0 keeps, write 1 clears
        wr(5'h0B, 8'h0E);
        check("R9 zero keeps", 32'(hit_status), 32'h1);
        wr(5'h0B, 8'h01);
        check("R9 one clears", 32'(hit_status), 0);

        // R9 set wins over clear in the same cycle
        @(negedge clk);
        pc = 24'h001234; pc_start = 1'b1;
        bus_wr = 1'b1; bus_addr = 5'h0B; bus_wdata = 8'h01;
        @(negedge clk);
        pc_start = 1'b0; bus_wr = 1'b0;
        check("R9 set beats clear", 32'(hit_status), 32'h1);
        wr(5'h0B, 8'h0F);

        // R5 no strobe, no request
        strobe(24'h001234, 1'b0);
        check("R5 no strobe req", 32'(irq_req), 0);
        check("R5 no strobe status", 32'(hit_status), 0);

        // R10 write in same cycle as strobe uses the old target
        @(negedge clk);
        pc = 24'h001234; pc_start = 1'b1;
        bus_wr = 1'b1; bus_addr = 5'h10; bus_wdata = 8'h35;
        @(negedge clk);
        pc_start = 1'b0; bus_wr = 1'b0;
        check("R10 old target matches", 32'(irq_req), 1);
        wr(5'h0B, 8'h0F);
        strobe(24'h001234, 1'b1);
        check("R10 old value gone", 32'(irq_req), 0);
        strobe(24'h001235, 1'b1);
        check("R10 new value matches", 32'(irq_req), 1);
        wr(5'h0B, 8'h0F);

        // R6 disabled channel
        wr(5'h09, 8'h0E);
        strobe(24'h001235, 1'b1);
        check("R6 disabled req", 32'(irq_req), 0);
        check("R6 disabled status", 32'(hit_status), 0);
        wr(5'h09, 8'h07);
        strobe(24'h7F0000, 1'b1);
        check("R6 R7 chan2 only", 32'(irq_chan), 2);
        check("R6 status only ch2", 32'(hit_status), 32'h4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule